// File: doc/BRIEF.md
# Private Peripheral Region Router

This block sits between a processor's load/store path and the small set of register blocks that live in its private peripheral region, 0xE000_0000 to 0xE00F_FFFF. Each access arrives with an address, a write flag, write data, a privilege bit and a security bit. The block decides which register target owns the address and raises that target's select strobe in the same cycle. It then returns the target's read data and error flag as a registered response, one cycle after the request.

The possible targets are:

- the system-control target, which holds the interrupt controller and the system registers;
- two timer instances, one secure and one non-secure;
- an optional error-reporting register target.

Addresses that no target claims are answered by a built-in responder. It returns zero to privileged reads, drops privileged writes, and faults unprivileged accesses.

A secure-only alias window lets secure software reach the non-secure view of the system-control and timer registers. Where windows overlap, a fixed priority settles the owner: the timer and error windows win over the system-control window, which wins over the built-in responder.

Top module: `ppb_router`

## Requirements
- R1: A privileged access to an address that no target claims (including any address outside 0xE000_0000..0xE00F_FFFF) raises no select bit. It is answered with rsp_rdata = 0 and rsp_fault = 0, and a write of this kind reaches no target.
- R2: An unprivileged access to an unclaimed address is answered with rsp_fault = 1.
- R3: Addresses 0xE000_E000..0xE000_EFFF outside the timer window select the system-control target (tgt_sel bit 0). tgt_offset is address bits [11:0], and tgt_secure and tgt_priv follow the request.
- R4: The timer window 0xE000_E010..0xE000_E0EF takes priority over the system-control target, and tgt_offset is the address minus 0xE000_E010. A secure access selects the secure timer (bit 1) and a non-secure access selects the non-secure timer (bit 2). 0xE000_E00C and 0xE000_E0F0 fall back to the system-control target.
- R5: When the error target is configured, 0xE000_5000..0xE000_5FFF selects it (bit 3) with tgt_offset = address bits [11:0]. When it is not configured, those addresses go to the built-in responder.
- R6: A secure access to the alias window 0xE002_E000..0xE002_EFFF is forwarded with tgt_secure = 0. Offsets 0x010..0x0EF go to the non-secure timer with tgt_offset = offset − 0x010. All other offsets go to the system-control target at the same offset.
- R7: A non-secure access to the alias window goes to the built-in responder: read-as-zero and write-ignored when privileged, a fault when unprivileged.
- R8: At most one tgt_sel bit is high, and none while req_valid is low.
- R9: rsp_valid is high exactly in the cycle after each request. rsp_rdata is the selected target's read lane for reads and zero for writes. rsp_fault is the selected target's fault bit.
- R10: With the security extension off, timer accesses always select the non-secure timer and tgt_secure is 0. With the alias disabled, alias addresses go to the built-in responder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_priv | input | 1 | 1 = privileged access |
| req_secure | input | 1 | 1 = secure access |
| tgt_sel | output | 4 | One-hot target select: 0 system-control, 1 secure timer, 2 non-secure timer, 3 error registers |
| tgt_offset | output | 12 | Offset inside the selected target |
| tgt_write | output | 1 | Write flag to targets |
| tgt_wdata | output | 32 | Write data to targets |
| tgt_priv | output | 1 | Privilege seen by targets |
| tgt_secure | output | 1 | Security attribute seen by targets (after alias rewrite) |
| tgt_rdata | input | 128 | Read lanes, lane k at bits [32k+31:32k] |
| tgt_fault | input | 4 | Per-target fault flags |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | 32 | Response read data |
| rsp_fault | output | 1 | Response bus fault |

## Verification
Several rules hold on every cycle and are checked as such:

- the select vector stays one-hot or empty;
- a response follows every request, and only a request;
- the secure timer is never picked for a non-secure access;
- the alias window never forwards a secure attribute and never serves a non-secure access;
- unclaimed accesses answer zero or fault according to privilege.

Exact window edges, offset arithmetic, lane selection for read data, and the two reduced configurations can only be shown by the bench's directed accesses. These are compared against an address model held in the bench.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  localparam int NUM_TGT = 4;

  typedef enum logic [2:0] {
    TGT_SYSCTL  = 3'd0,
    TGT_TMR_SEC = 3'd1,
    TGT_TMR_NS  = 3'd2,
    TGT_ERRREG  = 3'd3,
    TGT_NONE    = 3'd4
  } tgt_e;

  localparam logic [31:0] SCS_BASE   = 32'hE000_E000;
  localparam logic [32:0] SCS_SIZE   = 33'h0000_1000;
  localparam logic [31:0] TMR_BASE   = 32'hE000_E010;
  localparam logic [32:0] TMR_SIZE   = 33'h0000_00E0;
  localparam logic [31:0] ALIAS_BASE = 32'hE002_E000;
  localparam logic [31:0] ATMR_BASE  = 32'hE002_E010;
  localparam logic [31:0] ERR_BASE   = 32'hE000_5000;
  localparam logic [32:0] ERR_SIZE   = 33'h0000_1000;
  localparam logic [11:0] TMR_REL    = 12'h010;
endpackage

// File: rtl/ppb_window.sv
module ppb_window #(
  parameter int          AW     = 32,
  parameter logic [AW-1:0] BASE = '0,
  parameter logic [AW:0]   SIZE = 1,
  parameter bit          ENABLE = 1'b1
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  generate
    if (ENABLE) begin : g_on
      logic [AW:0] addr_ext;
      logic [AW:0] limit;
      assign addr_ext = {1'b0, addr};
      assign limit    = {1'b0, BASE} + SIZE;
      assign hit      = (addr >= BASE) && (addr_ext < limit);
    end else begin : g_off
      logic unused_addr;
      assign unused_addr = ^addr;
      assign hit         = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ppb_decode.sv
module ppb_decode
  import ppb_pkg::*;
#(
  parameter bit HAS_SECURITY = 1'b1,
  parameter bit HAS_ALIAS    = 1'b1,
  parameter bit HAS_ERRREG   = 1'b1,
  parameter int OFS_W        = 12
) (
  input  logic [31:0]      addr,
  input  logic             secure,
  output tgt_e             tgt,
  output logic [OFS_W-1:0] offset,
  output logic             fwd_secure
);
  logic hit_scs, hit_tmr, hit_alias, hit_atmr, hit_err;

  ppb_window #(.AW(32), .BASE(SCS_BASE),   .SIZE(SCS_SIZE), .ENABLE(1'b1))
    u_win_scs   (.addr(addr), .hit(hit_scs));
  ppb_window #(.AW(32), .BASE(TMR_BASE),   .SIZE(TMR_SIZE), .ENABLE(1'b1))
    u_win_tmr   (.addr(addr), .hit(hit_tmr));
  ppb_window #(.AW(32), .BASE(ALIAS_BASE), .SIZE(SCS_SIZE), .ENABLE(HAS_ALIAS))
    u_win_alias (.addr(addr), .hit(hit_alias));
  ppb_window #(.AW(32), .BASE(ATMR_BASE),  .SIZE(TMR_SIZE), .ENABLE(HAS_ALIAS))
    u_win_atmr  (.addr(addr), .hit(hit_atmr));
  ppb_window #(.AW(32), .BASE(ERR_BASE),   .SIZE(ERR_SIZE), .ENABLE(HAS_ERRREG))
    u_win_err   (.addr(addr), .hit(hit_err));

  logic sec_in;
  assign sec_in = HAS_SECURITY ? secure : 1'b0;

  // Priority: high level (timer, alias timer, error) > system-control > default
  always_comb begin
    tgt        = TGT_NONE;
    offset     = addr[OFS_W-1:0];
    fwd_secure = sec_in;
    if (hit_err) begin
      tgt = TGT_ERRREG;
    end else if (hit_tmr) begin
      tgt    = sec_in ? TGT_TMR_SEC : TGT_TMR_NS;
      offset = addr[OFS_W-1:0] - OFS_W'(TMR_REL);
    end else if (hit_scs) begin
      tgt = TGT_SYSCTL;
    end else if (hit_atmr && sec_in) begin
      tgt        = TGT_TMR_NS;
      offset     = addr[OFS_W-1:0] - OFS_W'(TMR_REL);
      fwd_secure = 1'b0;
    end else if (hit_alias && sec_in) begin
      tgt        = TGT_SYSCTL;
      fwd_secure = 1'b0;
    end
  end
endmodule

// File: rtl/ppb_resp.sv
module ppb_resp #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_priv,
  input  logic          is_default,
  input  logic [DW-1:0] lane_rdata,
  input  logic          lane_fault,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_fault
);
  logic          valid_d;
  logic [DW-1:0] rdata_d;
  logic          fault_d;
  logic          data_en;

  always_comb begin
    valid_d = req_valid;
    data_en = req_valid | rsp_valid;
    rdata_d = '0;
    fault_d = 1'b0;
    if (req_valid) begin
      if (is_default) begin
        fault_d = ~req_priv;
      end else begin
        fault_d = lane_fault;
        if (!req_write) rdata_d = lane_rdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
      rsp_fault <= 1'b0;
    end else if (data_en) begin
      rsp_rdata <= rdata_d;
      rsp_fault <= fault_d;
    end
  end

  assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_only_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_write_no_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rsp_rdata == '0));
endmodule

// File: rtl/ppb_router.sv
module ppb_router
  import ppb_pkg::*;
#(
  parameter int DW           = 32,
  parameter int OFS_W        = 12,
  parameter bit HAS_SECURITY = 1'b1,
  parameter bit HAS_ALIAS    = 1'b1,
  parameter bit HAS_ERRREG   = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [31:0]           req_addr,
  input  logic                  req_write,
  input  logic [DW-1:0]         req_wdata,
  input  logic                  req_priv,
  input  logic                  req_secure,
  output logic [NUM_TGT-1:0]    tgt_sel,
  output logic [OFS_W-1:0]      tgt_offset,
  output logic                  tgt_write,
  output logic [DW-1:0]         tgt_wdata,
  output logic                  tgt_priv,
  output logic                  tgt_secure,
  input  logic [NUM_TGT*DW-1:0] tgt_rdata,
  input  logic [NUM_TGT-1:0]    tgt_fault,
  output logic                  rsp_valid,
  output logic [DW-1:0]         rsp_rdata,
  output logic                  rsp_fault
);
  logic rst_meta, rst_sync_n;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  tgt_e             dec_tgt;
  logic [OFS_W-1:0] dec_offset;
  logic             dec_secure;

  ppb_decode #(
    .HAS_SECURITY(HAS_SECURITY), .HAS_ALIAS(HAS_ALIAS),
    .HAS_ERRREG(HAS_ERRREG), .OFS_W(OFS_W)
  ) u_decode (
    .addr(req_addr), .secure(req_secure),
    .tgt(dec_tgt), .offset(dec_offset), .fwd_secure(dec_secure)
  );

  generate
    for (genvar k = 0; k < NUM_TGT; k++) begin : g_sel
      assign tgt_sel[k] = req_valid && (dec_tgt == tgt_e'(k));
    end
  endgenerate

  assign tgt_offset = dec_offset;
  assign tgt_write  = req_write;
  assign tgt_wdata  = req_wdata;
  assign tgt_priv   = req_priv;
  assign tgt_secure = dec_secure;

  logic [DW-1:0] lane_rdata;
  logic          lane_fault;
  logic          is_default;

  always_comb begin
    lane_rdata = '0;
    for (int k = 0; k < NUM_TGT; k++) begin
      if (tgt_sel[k]) lane_rdata = lane_rdata | tgt_rdata[k*DW +: DW];
    end
  end
  assign lane_fault = |(tgt_fault & tgt_sel);
  assign is_default = (tgt_sel == '0);

  ppb_resp #(.DW(DW)) u_resp (
    .clk(clk), .rst_n(rst_sync_n),
    .req_valid(req_valid), .req_write(req_write), .req_priv(req_priv),
    .is_default(is_default), .lane_rdata(lane_rdata), .lane_fault(lane_fault),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault)
  );

  logic in_alias;
  assign in_alias = (req_addr[31:12] == 20'hE002E);

  assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(tgt_sel));
  assert_sel_idle_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |-> (tgt_sel == '0));
  assert_sec_timer_bank_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tgt_sel[1] |-> req_secure);
  assert_alias_strips_secure_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && in_alias && (tgt_sel != '0)) |-> !tgt_secure);
  assert_alias_ns_default_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && in_alias && !req_secure) |-> (tgt_sel == '0));
  assert_default_fault_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && (tgt_sel == '0) && !req_priv) |=> rsp_fault);
  assert_default_raz_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && (tgt_sel == '0) && req_priv) |=> (!rsp_fault && rsp_rdata == '0));
endmodule

// File: tb/ppb_router_test.sv
module ppb_router_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        req_priv = 1'b0;
  logic        req_secure = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  logic [3:0]   a_sel, b_sel;
  logic [11:0]  a_ofs, b_ofs;
  logic         a_wr, b_wr, a_pr, b_pr, a_sec, b_sec;
  logic [31:0]  a_wd, b_wd;
  logic [127:0] a_rd, b_rd;
  logic [3:0]   a_flt, b_flt;
  logic         a_rv, b_rv, a_rf, b_rf;
  logic [31:0]  a_rdat, b_rdat;

  ppb_router uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .req_priv(req_priv),
    .req_secure(req_secure), .tgt_sel(a_sel), .tgt_offset(a_ofs),
    .tgt_write(a_wr), .tgt_wdata(a_wd), .tgt_priv(a_pr), .tgt_secure(a_sec),
    .tgt_rdata(a_rd), .tgt_fault(a_flt),
    .rsp_valid(a_rv), .rsp_rdata(a_rdat), .rsp_fault(a_rf));

  ppb_router #(.HAS_SECURITY(1'b0), .HAS_ALIAS(1'b0), .HAS_ERRREG(1'b0)) uut_min (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .req_priv(req_priv),
    .req_secure(req_secure), .tgt_sel(b_sel), .tgt_offset(b_ofs),
    .tgt_write(b_wr), .tgt_wdata(b_wd), .tgt_priv(b_pr), .tgt_secure(b_sec),
    .tgt_rdata(b_rd), .tgt_fault(b_flt),
    .rsp_valid(b_rv), .rsp_rdata(b_rdat), .rsp_fault(b_rf));

  // Target stubs: lane k returns {A, k, 000, offset}; error lane faults at 0xFFC
  for (genvar k = 0; k < 4; k++) begin : g_stub
    assign a_rd[k*32 +: 32] = {4'hA, 4'(k), 12'h000, a_ofs};
    assign b_rd[k*32 +: 32] = {4'hA, 4'(k), 12'h000, b_ofs};
  end
  assign a_flt = {a_ofs == 12'hFFC, 3'b000};
  assign b_flt = {b_ofs == 12'hFFC, 3'b000};

  int n_vec = 0;
  int n_bad = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct {int tgt; logic [11:0] ofs; logic sec;} route_t;
  typedef struct {string req; logic [31:0] ard; logic af; logic [31:0] brd; logic bf;} exp_t;
  exp_t sb[$];

  function automatic route_t model(bit sec_on, bit alias_on, bit err_on,
                                   logic [31:0] a, logic s);
    route_t r;
    logic [11:0] lo;
    bit tw;
    lo = a[11:0];
    tw = (lo >= 12'h010) && (lo <= 12'h0EF);
    r.tgt = 4; r.ofs = lo; r.sec = sec_on ? s : 1'b0;
    if (err_on && a[31:12] == 20'hE0005) r.tgt = 3;
    else if (a[31:12] == 20'hE000E && tw) begin
      r.tgt = (sec_on && s) ? 1 : 2; r.ofs = lo - 12'h010;
    end else if (a[31:12] == 20'hE000E) r.tgt = 0;
    else if (alias_on && sec_on && s && a[31:12] == 20'hE002E) begin
      r.tgt = tw ? 2 : 0; r.ofs = tw ? lo - 12'h010 : lo; r.sec = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(route_t r, logic wr);
    if (r.tgt == 4 || wr) return 32'h0;
    return {4'hA, 4'(r.tgt), 12'h000, r.ofs};
  endfunction

  function automatic logic exp_flt(route_t r, logic pr);
    if (r.tgt == 4) return ~pr;
    return (r.tgt == 3) && (r.ofs == 12'hFFC);
  endfunction

  task automatic drive(string req, logic [31:0] addr, logic wr, logic pr, logic sc);
    route_t ra, rb;
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_write = wr;
    req_wdata = addr ^ 32'h5A5A_0000; req_priv = pr; req_secure = sc;
    #1;
    ra = model(1, 1, 1, addr, sc);
    rb = model(0, 0, 0, addr, sc);
    chk(req, "sel", 64'(a_sel), (ra.tgt == 4) ? 64'h0 : 64'(1 << ra.tgt));
    chk(req, "min sel", 64'(b_sel), (rb.tgt == 4) ? 64'h0 : 64'(1 << rb.tgt));
    if (ra.tgt != 4) begin
      chk(req, "ofs", 64'(a_ofs), 64'(ra.ofs));
      chk(req, "sec", 64'(a_sec), 64'(ra.sec));
      chk(req, "priv", 64'(a_pr), 64'(pr));
    end
    if (rb.tgt != 4) begin
      chk(req, "min ofs", 64'(b_ofs), 64'(rb.ofs));
      chk(req, "min sec", 64'(b_sec), 64'(rb.sec));
    end
    e.req = req;
    e.ard = exp_rd(ra, wr); e.af = exp_flt(ra, pr);
    e.brd = exp_rd(rb, wr); e.bf = exp_flt(rb, pr);
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: response one cycle after the request (R9)
  always @(negedge clk) begin
    if (rst_n) begin
      if (a_rv || b_rv) begin
        if (sb.size() == 0) begin
          chk("R9", "unexpected rsp", 64'(a_rv), 64'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(e.req, "rsp_valid", 64'({a_rv, b_rv}), 64'h3);
          chk(e.req, "rdata", 64'(a_rdat), 64'(e.ard));
          chk(e.req, "fault", 64'(a_rf), 64'(e.af));
          chk(e.req, "min rdata", 64'(b_rdat), 64'(e.brd));
          chk(e.req, "min fault", 64'(b_rf), 64'(e.bf));
        end
      end else if (sb.size() != 0 && !req_valid) begin
        chk("R9", "missing rsp", 64'(a_rv), 64'h1);
        void'(sb.pop_front());
      end
    end
  end

  initial begin
    #(PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 reset", "sel", 64'(a_sel), 64'h0);
    chk("R9 reset", "rsp_valid", 64'(a_rv), 64'h0);
    // R1 unclaimed, privileged
    drive("R1 raz", 32'hE000_1000, 1'b0, 1'b1, 1'b1);
    drive("R1 wi", 32'hE000_1000, 1'b1, 1'b1, 1'b0);
    drive("R1 outside", 32'h2000_0000, 1'b0, 1'b1, 1'b1);
    // R2 unprivileged default
    drive("R2 fault", 32'hE000_1000, 1'b0, 1'b0, 1'b0);
    // R3 system-control
    drive("R3 irq", 32'hE000_E100, 1'b0, 1'b1, 1'b1);
    drive("R3 sysreg", 32'hE000_ED00, 1'b0, 1'b0, 1'b0);
    drive("R3 wr", 32'hE000_ED3C, 1'b1, 1'b1, 1'b1);
    // R4 timer window and edges
    drive("R4 sec lo", 32'hE000_E010, 1'b0, 1'b1, 1'b1);
    drive("R4 ns hi", 32'hE000_E0EF, 1'b0, 1'b1, 1'b0);
    drive("R4 edge hi", 32'hE000_E0F0, 1'b0, 1'b1, 1'b1);
    drive("R4 edge lo", 32'hE000_E00C, 1'b0, 1'b1, 1'b0);
    // R5 error registers
    drive("R5 base", 32'hE000_5000, 1'b0, 1'b1, 1'b1);
    drive("R5 fault", 32'hE000_5FFC, 1'b0, 1'b1, 1'b0);
    idle(2);
    // R6 secure alias forwarding
    drive("R6 sysreg", 32'hE002_ED00, 1'b0, 1'b1, 1'b1);
    drive("R6 timer", 32'hE002_E018, 1'b0, 1'b1, 1'b1);
    drive("R6 wr", 32'hE002_E0EC, 1'b1, 1'b0, 1'b1);
    // R7 non-secure alias
    drive("R7 raz", 32'hE002_ED00, 1'b0, 1'b1, 1'b0);
    drive("R7 fault", 32'hE002_E010, 1'b0, 1'b0, 1'b0);
    // R10 reduced configuration shown via uut_min on the same traffic
    drive("R10 sec timer", 32'hE000_E020, 1'b0, 1'b1, 1'b1);
    idle(3);
    chk("R9 drain", "pending", 64'(sb.size()), 64'h0);
    chk("R8 idle", "sel", 64'(a_sel), 64'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule